// File: doc/BRIEF.md
# Partitioned Byte-Wide Memory Decoder

This block sits between an 8051-style core and a non-multiplexed byte-wide SRAM bus. Each cycle the core may present one access: a program fetch or a data (MOVX) read or write, with a 16-bit address. The decoder registers the access and, one cycle later, drives a 15-bit memory address, two active-low chip enables, an active-low write enable and a request for the expanded (port-based) bus when the address does not land in the byte-wide memory.

The lower 32 KB (0000h–7FFFh) is served by chip enable 1. A partition register splits that window at a boundary of `field × 128` bytes. Addresses below the boundary are code, and the SRAM never receives a write for them. Addresses at or above the boundary are data. The upper 32 KB can be bank-switched onto chip enable 2, but only for data accesses. Program fetches there, and data accesses with the bank switch off, become expanded-bus requests. The two upper memory address bits leave the block inverted. A power-fail input takes every strobe inactive in the same cycle and drops the accesses that arrive while it is active.

The core of the block is a Moore state machine. Each state names the kind of bus cycle being driven:
- `S_IDLE`: no access.
- `S_RD1`: chip enable 1 read. This covers every fetch and every data read below 8000h.
- `S_WR1`: chip enable 1 write into the data region.
- `S_PROT`: a write aimed at the code region. The SRAM sees a read and no write strobe.
- `S_RD2`, `S_WR2`: data read and write on chip enable 2.
- `S_EXP`: expanded-bus request.
- `S_PFAIL`: power fail.

Transitions:
- From any state, the next state is `S_PFAIL` while `pfail` is high.
- Otherwise, with no request the next state is `S_IDLE`.
- Otherwise the request class picks the next state, as listed above.

Top module: `bytewide_decoder`

## Requirements
- R1: After reset, `ce1_n`, `ce2_n` and `we_n` are 1, `exp_req` is 0, and the partition field equals `PART_INIT` (default 20h, boundary 1000h).
- R2: A request sampled at a rising edge drives the outputs from that edge until the next edge (one cycle of latency).
- R3: Any request with address bit 15 clear asserts `ce1_n` (0), keeps `ce2_n` at 1 and `exp_req` at 0.
- R4: `mem_addr[12:0]` equals address bits 12:0, and `mem_addr[14:13]` equals the inverse of address bits 14:13.
- R5: The boundary is `field × 128`. A write with address[14:7] below the field keeps `we_n` at 1 and still asserts `ce1_n`. A write with address[14:7] at or above the field asserts `we_n`.
- R6: A program fetch anywhere in 0000h–7FFFh, including the data region, asserts `ce1_n` and keeps `we_n` at 1.
- R7: A `part_load` pulse at an edge replaces the field for requests sampled at later edges. A request sampled at the same edge still uses the old field.
- R8: A data access with bit 15 set and `bank2_sel`=1 asserts `ce2_n`, keeps `ce1_n` at 1 and `exp_req` at 0, and asserts `we_n` for a write (no protection applies).
- R9: A program fetch with bit 15 set, regardless of `bank2_sel`, and a data access with bit 15 set and `bank2_sel`=0 assert `exp_req` and keep `ce1_n`, `ce2_n` and `we_n` at 1.
- R10: While `pfail` is 1, `ce1_n`, `ce2_n` and `we_n` are 1 and `exp_req` is 0 in the same cycle. A request sampled while `pfail` is 1 is dropped. The first request after `pfail` falls decodes normally.
- R11: With `req_valid`=0 at an edge, the following cycle has all strobes inactive and `exp_req` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pfail | input | 1 | Power-fail reset, active high |
| part_load | input | 1 | Load the partition field |
| part_value | input | PART_W | New partition field |
| req_valid | input | 1 | Access present this cycle |
| req_is_data | input | 1 | 1 = data access, 0 = program fetch |
| req_wr | input | 1 | Write (data accesses only) |
| bank2_sel | input | 1 | Route upper 32 KB data to chip enable 2 |
| req_addr | input | ADDR_W | Logical address |
| mem_addr | output | BUS_AW | Byte-wide address, top two bits inverted |
| ce1_n | output | 1 | Chip enable 1, active low |
| ce2_n | output | 1 | Chip enable 2, active low |
| we_n | output | 1 | Write enable, active low |
| exp_req | output | 1 | Expanded-bus request |

## Verification
The bench aims at the following edges:
- **Partition boundary ±1, for several field values including 00h and FFh.** A comparison that is off by one would let a write land on the last code line or block the first data line.
- **The 7FFFh/8000h step for fetch and data with the bank switch in both settings.** A decoder that ignored the access type would hand a program fetch to chip enable 2.
- **A partition load in the same cycle as a write.** A design that forwarded the new field early would flip that write's protection.
- **Power-fail in the middle of a stream.** The strobes are checked in the same cycle, and the first request after release is checked as well.

Random vectors biased toward these edges cover the remaining cases against a bench-side model.

// File: rtl/bwdec_pkg.sv
package bwdec_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_RD1,
        S_WR1,
        S_PROT,
        S_RD2,
        S_WR2,
        S_EXP,
        S_PFAIL
    } bw_state_e;
endpackage

// File: rtl/bwdec_part_reg.sv
module bwdec_part_reg #(
    parameter int              PART_W    = 8,
    parameter logic [PART_W-1:0] PART_INIT = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [PART_W-1:0] value,
    output logic [PART_W-1:0] part_q
);
    // R7: new field is seen only by requests sampled after this edge
    always_ff @(posedge clk) begin
        if (!rst_n)
            part_q <= PART_INIT;
        else if (load)
            part_q <= value;
    end
endmodule

// File: rtl/bwdec_region.sv
module bwdec_region
    import bwdec_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BUS_AW = 15,
    parameter int PART_W = 8
) (
    input  logic              valid,
    input  logic              is_data,
    input  logic              wr,
    input  logic              bank2,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PART_W-1:0] part,
    output bw_state_e         next_state
);
    logic              upper;
    logic [PART_W-1:0] line_idx;
    logic              in_code;

    assign upper    = addr[ADDR_W-1];
    assign line_idx = addr[BUS_AW-1 -: PART_W];
    assign in_code  = (line_idx < part);

    always_comb begin
        next_state = S_IDLE;
        if (!valid) begin
            next_state = S_IDLE;                         // R11
        end else if (!upper) begin                       // R3
            if (is_data && wr)
                next_state = in_code ? S_PROT : S_WR1;   // R5
            else
                next_state = S_RD1;                      // R6
        end else if (is_data && bank2) begin             // R8
            next_state = wr ? S_WR2 : S_RD2;
        end else begin
            next_state = S_EXP;                          // R9
        end
    end
endmodule

// File: rtl/bytewide_decoder.sv
module bytewide_decoder
    import bwdec_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                BUS_AW    = 15,
    parameter int                PART_W    = 8,
    parameter int                INV_BITS  = 2,
    parameter logic [PART_W-1:0] PART_INIT = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pfail,
    input  logic              part_load,
    input  logic [PART_W-1:0] part_value,
    input  logic              req_valid,
    input  logic              req_is_data,
    input  logic              req_wr,
    input  logic              bank2_sel,
    input  logic [ADDR_W-1:0] req_addr,
    output logic [BUS_AW-1:0] mem_addr,
    output logic              ce1_n,
    output logic              ce2_n,
    output logic              we_n,
    output logic              exp_req
);
    localparam int PLAIN_BITS = BUS_AW - INV_BITS;

    bw_state_e         state_q, next_state;
    logic [PART_W-1:0] part_q;
    logic [BUS_AW-1:0] addr_q;
    logic              ce1_raw, ce2_raw, we_raw, exp_raw;

    bwdec_part_reg #(.PART_W(PART_W), .PART_INIT(PART_INIT)) u_part (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (part_load),
        .value  (part_value),
        .part_q (part_q)
    );

    bwdec_region #(.ADDR_W(ADDR_W), .BUS_AW(BUS_AW), .PART_W(PART_W)) u_region (
        .valid      (req_valid),
        .is_data    (req_is_data),
        .wr         (req_wr),
        .bank2      (bank2_sel),
        .addr       (req_addr),
        .part       (part_q),
        .next_state (next_state)
    );

    // State register (R2: one cycle of latency)
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else if (pfail)
            state_q <= S_PFAIL;
        else
            state_q <= next_state;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (req_valid && !pfail)
            addr_q <= req_addr[BUS_AW-1:0];
    end

    // Output decode per state
    always_comb begin
        ce1_raw = 1'b1;
        ce2_raw = 1'b1;
        we_raw  = 1'b1;
        exp_raw = 1'b0;
        unique case (state_q)
            S_IDLE:  ;
            S_RD1:   ce1_raw = 1'b0;
            S_WR1:   begin ce1_raw = 1'b0; we_raw = 1'b0; end
            S_PROT:  ce1_raw = 1'b0;
            S_RD2:   ce2_raw = 1'b0;
            S_WR2:   begin ce2_raw = 1'b0; we_raw = 1'b0; end
            S_EXP:   exp_raw = 1'b1;
            S_PFAIL: ;
            default: ;
        endcase
    end

    // R10: power fail quiets every strobe in the same cycle
    assign ce1_n   = ce1_raw | pfail;
    assign ce2_n   = ce2_raw | pfail;
    assign we_n    = we_raw  | pfail;
    assign exp_req = exp_raw & ~pfail;

    // R4: upper address bits leave inverted
    for (genvar i = 0; i < BUS_AW; i++) begin : g_abit
        if (i >= PLAIN_BITS) begin : g_inv
            assign mem_addr[i] = ~addr_q[i];
        end else begin : g_plain
            assign mem_addr[i] = addr_q[i];
        end
    end

    // Assertions
    p_ce_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ce1_n && !ce2_n));

    p_exp_no_ce_r9: assert property (@(posedge clk) disable iff (!rst_n)
        exp_req |-> (ce1_n && ce2_n && we_n));

    p_fetch_not_ce2_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_data) |=> ce2_n);

    p_no_rom_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && !ce1_n) |-> (addr_q[BUS_AW-1 -: PART_W] >= $past(part_q)));

    p_pfail_state_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pfail |=> (state_q == S_PFAIL));

    p_addr_inv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !pfail) |=>
            (mem_addr[BUS_AW-1 -: INV_BITS] == ~$past(req_addr[BUS_AW-1 -: INV_BITS])));
endmodule

// File: tb/bytewide_decoder_test.sv
module bytewide_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pfail = 1'b0;
    logic        part_load = 1'b0;
    logic [7:0]  part_value = '0;
    logic        req_valid = 1'b0;
    logic        req_is_data = 1'b0;
    logic        req_wr = 1'b0;
    logic        bank2_sel = 1'b0;
    logic [15:0] req_addr = '0;
    logic [14:0] mem_addr;
    logic        ce1_n, ce2_n, we_n, exp_req;

    int          n_vec  = 0;
    int          n_fail = 0;
    bit          done   = 1'b0;
    logic [7:0]  part_m = 8'h20;

    always #4 clk = ~clk;

    bytewide_decoder uut (
        .clk(clk), .rst_n(rst_n), .pfail(pfail), .part_load(part_load),
        .part_value(part_value), .req_valid(req_valid), .req_is_data(req_is_data),
        .req_wr(req_wr), .bank2_sel(bank2_sel), .req_addr(req_addr),
        .mem_addr(mem_addr), .ce1_n(ce1_n), .ce2_n(ce2_n), .we_n(we_n),
        .exp_req(exp_req)
    );

    // Expected {ce1_n, ce2_n, we_n, exp_req}
    function automatic logic [3:0] model(logic v, logic d, logic w, logic b2,
                                         logic [15:0] a, logic [7:0] p, logic pf);
        if (pf || !v) return 4'b1110;
        if (!a[15]) begin
            if (d && w && a[14:7] >= p) return 4'b0100;
            return 4'b0110;
        end
        if (d && b2) return w ? 4'b1000 : 4'b1010;
        return 4'b1111;
    endfunction

    function automatic string tag_of(logic v, logic d, logic w, logic b2,
                                     logic [15:0] a, logic pf);
        if (pf) return "R10";
        if (!v) return "R11";
        if (!a[15]) return (d && w) ? "R5" : (d ? "R3" : "R6");
        if (d && b2) return "R8";
        return "R9";
    endfunction

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    endtask

    task automatic check4(string tag, logic [3:0] got, logic [3:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s strobes {ce1_n,ce2_n,we_n,exp_req} got %b expected %b", tag, got, exp);
        end
    endtask

    // Called at a negedge: drive, pass one rising edge, check at next negedge
    task automatic step(logic v, logic d, logic w, logic b2, logic [15:0] a,
                        logic pf, logic ld, logic [7:0] lv, string tag_in);
        logic [3:0]  e;
        logic [14:0] ea;
        string       t;
        req_valid = v; req_is_data = d; req_wr = w; bank2_sel = b2; req_addr = a;
        pfail = pf; part_load = ld; part_value = lv;
        e  = model(v, d, w, b2, a, part_m, pf);
        ea = {~a[14:13], a[12:0]};
        t  = (tag_in != "") ? tag_in : tag_of(v, d, w, b2, a, pf);
        if (pf) begin
            #1;
            check4("R10 same-cycle", {ce1_n, ce2_n, we_n, exp_req}, 4'b1110);
        end
        if (ld) part_m = lv;
        @(posedge clk);
        @(negedge clk);
        check4(t, {ce1_n, ce2_n, we_n, exp_req}, e);
        if (v && !pf) begin
            n_vec++;
            if (mem_addr !== ea) begin
                n_fail++;
                $display("FAIL R4 mem_addr got %h expected %h (addr %h)", mem_addr, ea, a);
            end
        end
    endtask

    function automatic logic [15:0] pick_addr(logic [7:0] p);
        int k = $urandom_range(0, 7);
        case (k)
            0: return {1'b0, p, 7'h00};
            1: return {1'b0, p, 7'h00} - 16'd1;
            2: return 16'h7FFF;
            3: return 16'h8000;
            4: return 16'h0000;
            5: return 16'hFFFF;
            default: return 16'($urandom);
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_vec++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check4("R1 reset", {ce1_n, ce2_n, we_n, exp_req}, 4'b1110);

        step(0, 0, 0, 0, 16'h0100, 0, 0, 8'h00, "R11 idle");
        // R1/R5: reset field 20h -> boundary 1000h
        step(1, 1, 1, 0, 16'h0FFF, 0, 0, 8'h00, "R1 R5 below reset boundary");
        step(1, 1, 1, 0, 16'h1000, 0, 0, 8'h00, "R1 R5 at reset boundary");
        step(1, 0, 0, 0, 16'h1000, 0, 0, 8'h00, "R6 fetch from data region");
        step(1, 0, 0, 0, 16'h0000, 0, 0, 8'h00, "R6 fetch from code region");
        // R7: same-edge load uses old field
        step(1, 1, 1, 0, 16'h2000, 0, 1, 8'h80, "R7 same-edge write old field");
        step(1, 1, 1, 0, 16'h2000, 0, 0, 8'h00, "R7 write after load");
        step(1, 1, 1, 0, 16'h3FFF, 0, 0, 8'h00, "R5 boundary-1");
        step(1, 1, 1, 0, 16'h4000, 0, 0, 8'h00, "R5 boundary");
        step(1, 1, 1, 0, 16'h7FFF, 0, 0, 8'h00, "R3 top of window");
        step(1, 1, 1, 1, 16'h8000, 0, 0, 8'h00, "R8 bank2 write");
        step(1, 1, 0, 1, 16'hFFFF, 0, 0, 8'h00, "R8 bank2 read");
        step(1, 1, 1, 0, 16'h8000, 0, 0, 8'h00, "R9 data no bank2");
        step(1, 0, 0, 1, 16'h8000, 0, 0, 8'h00, "R9 fetch ignores bank2");
        step(1, 1, 0, 0, 16'h6000, 0, 0, 8'h00, "R4 inversion");
        step(1, 1, 0, 0, 16'h1234, 0, 1, 8'h00, "R4 inversion");
        step(1, 1, 1, 0, 16'h0000, 0, 0, 8'h00, "R5 field zero all data");
        step(0, 0, 0, 0, 16'h0000, 0, 1, 8'hFF, "R11 idle with load");
        step(1, 1, 1, 0, 16'h7F7F, 0, 0, 8'h00, "R5 field FF below");
        step(1, 1, 1, 0, 16'h7F80, 0, 0, 8'h00, "R5 field FF at");
        step(1, 1, 1, 1, 16'h9000, 1, 0, 8'h00, "R10 pfail drops write");
        step(1, 1, 1, 0, 16'h7F80, 1, 0, 8'h00, "R10 pfail held");
        step(1, 1, 1, 0, 16'h7F80, 0, 0, 8'h00, "R10 first after release");
        step(1, 0, 0, 0, 16'h0040, 0, 0, 8'h00, "R2 back-to-back");

        for (int i = 0; i < 4000; i++) begin
            logic       ld = ($urandom_range(0, 15) == 0);
            logic       pf = ($urandom_range(0, 31) == 0);
            logic       v  = ($urandom_range(0, 7) != 0);
            logic [7:0] lv = 8'($urandom);
            step(v, 1'($urandom), 1'($urandom), 1'($urandom), pick_addr(part_m),
                 pf, ld, lv, "");
        end
        finish_up();
    end
endmodule